// File: doc/BRIEF.md
# Framed Serial Word Transmitter

This block turns a 22-bit parallel word into a serial frame. The frame goes out on one data line, with a companion serial clock line beside it. A rising edge on the strobe input captures the parallel word into a holding register. Each new frame takes its content from that register when the frame begins. While the transmitter stays enabled, frames follow one another with no gap, and each frame repeats the most recently captured word.

A frame has 26 bit slots. The first two slots are a word-boundary marker. During the marker the serial clock stays low, and the data line goes from 1 to 0. That pattern cannot appear anywhere else, because in every data slot the clock rises and the data is held steady. Next come 24 data slots, lowest first. The 22 user bits fill the first 22 data slots, and the top two slots always carry 0.

A two-bit range selector picks how many reference-clock cycles one slot lasts. The highest range halves the serial rate. The frame format is the same in every range. When the enable is removed, the frame already in progress still runs to its end. After that, both lines are held low.

Top module: `frame_ser_tx`

## Requirements
- R1: While reset is asserted, and after reset until a frame starts, `ser_data` and `ser_clk` are both 0.
- R2: Every frame is exactly 26 slots long: 2 boundary slots followed by 24 data slots, in every range setting.
- R3: In boundary slot 0, `ser_data` is 1. In boundary slot 1, `ser_data` is 0. `ser_clk` is 0 throughout both boundary slots.
- R4: Data slot n (n = 1..22) carries `din[n-1]` of the word in the frame. Data slots are sent in order from slot 1 to slot 24, immediately after the boundary slots.
- R5: Data slots 23 and 24 are always 0, whatever the input word is.
- R6: A slot lasts L cycles. In every data slot, `ser_clk` is 0 for the first floor(L/2) cycles and 1 for the remaining cycles. `ser_data` changes only at slot starts.
- R7: `range_sel` sets L. A value of 1 gives L = SLOT_M1, a value of 2 gives L = SLOT_M2, and a value of 3 gives L = 2*SLOT_M3 (half rate). L is sampled when a frame starts, so changing `range_sel` in mid-frame only affects the next frame.
- R8: A word is captured only in a cycle where `strobe` is 1 and was 0 in the cycle before. Changes on `din` without such an edge are ignored. A word captured during a frame first appears in the next frame. Back-to-back frames repeat the last captured word.
- R9: If `enable` is 0 at the end of a frame, or `range_sel` is 0, no new frame starts, and both outputs stay 0. A frame that is already running completes even if `enable` drops partway through it.
- R10: From idle, a frame begins with slot 0 in the cycle after the first clock edge at which `enable` is 1 and `range_sel` is non-zero. While this condition holds, the next frame begins in the cycle right after slot 25 of the current frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Allows new frames to start |
| range_sel | input | 2 | Clock-range selector: 0 off, 1..3 set the slot length |
| strobe | input | 1 | A rising edge captures `din` |
| din | input | DATA_W | Parallel word to send |
| ser_data | output | 1 | Serial data line |
| ser_clk | output | 1 | Companion serial clock |

## Verification
The bench builds the block with SLOT_M1 = 4, SLOT_M2 = 2 and SLOT_M3 = 3. This gives slot lengths of 4, 2 and 6 cycles. Every range is therefore short enough to check in each cycle of whole frames. The 6-cycle case tests the half-rate doubling, and the 2-cycle case is the shortest slot the clock phase allows. Because the three lengths differ, the bench can see whether a range change made in mid-frame leaks into the current frame, or takes effect only at the next frame boundary.

// File: rtl/fst_pkg.sv
package fst_pkg;

  typedef enum logic [1:0] {
    RANGE_OFF  = 2'd0,
    RANGE_LOW  = 2'd1,
    RANGE_MID  = 2'd2,
    RANGE_HIGH = 2'd3
  } range_e;

  // Number of word-boundary slots that lead every frame.
  localparam int BOUND_SLOTS = 2;

  // Reference cycles per slot for a given range; the highest range runs
  // at half rate, so its base length is doubled.
  function automatic int slot_cycles(input range_e r, input int m1,
                                     input int m2, input int m3);
    case (r)
      RANGE_LOW:  return m1;
      RANGE_MID:  return m2;
      RANGE_HIGH: return 2 * m3;
      default:    return 0;
    endcase
  endfunction

  // Serial clock is high in the second half of a data slot.
  function automatic logic clk_high_phase(input int cyc, input int len);
    return cyc >= (len / 2);
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/fst_capture.sv
module fst_capture #(
  parameter int DATA_W = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic [DATA_W-1:0] din,
  output logic              strobe_rise,
  output logic [DATA_W-1:0] held
);

  logic strobe_q;

  assign strobe_rise = strobe & ~strobe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      held     <= '0;
    end else begin
      strobe_q <= strobe;
      if (strobe_rise) held <= din;
    end
  end

endmodule

// File: rtl/fst_slot_timer.sv
module fst_slot_timer #(
  parameter int CYC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CYC_W-1:0] len_in,
  input  logic             run,
  output logic [CYC_W-1:0] cyc,
  output logic [CYC_W-1:0] len,
  output logic             slot_end
);

  assign slot_end = run && (cyc == (len - CYC_W'(1)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc <= '0;
      len <= '0;
    end else if (load) begin
      cyc <= '0;
      len <= len_in;
    end else if (run) begin
      cyc <= slot_end ? '0 : cyc + CYC_W'(1);
    end
  end

endmodule

// File: rtl/fst_framer.sv
module fst_framer
  import fst_pkg::*;
#(
  parameter int DATA_W      = 22,
  parameter int PAD_W       = 2,
  parameter int FRAME_SLOTS = 26,
  parameter int SLOT_W      = 5,
  parameter int CYC_W       = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_ok,
  input  logic              slot_end,
  input  logic [DATA_W-1:0] held,
  input  logic [CYC_W-1:0]  cyc,
  input  logic [CYC_W-1:0]  len,
  output logic              start,
  output logic              frame_done,
  output logic              running,
  output logic [SLOT_W-1:0] slot,
  output logic              ser_data,
  output logic              ser_clk
);

  localparam int PAY_W = DATA_W + PAD_W;

  logic [PAY_W-1:0]       payload;
  logic [FRAME_SLOTS-1:0] frame_vec;
  logic                   last_slot;
  logic                   in_data;

  assign last_slot  = (slot == SLOT_W'(FRAME_SLOTS - 1));
  assign frame_done = running && slot_end && last_slot;
  assign start      = go_ok && (!running || frame_done);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      slot    <= '0;
      payload <= '0;
    end else if (start) begin
      running <= 1'b1;
      slot    <= '0;
      payload <= {{PAD_W{1'b0}}, held};
    end else if (running && slot_end) begin
      if (last_slot) begin
        running <= 1'b0;
        slot    <= '0;
      end else begin
        slot <= slot + SLOT_W'(1);
      end
    end
  end

  // Slot 0 carries 1, slot 1 carries 0, then the payload lowest bit first.
  assign frame_vec = {payload, 1'b0, 1'b1};
  assign in_data   = (slot >= SLOT_W'(BOUND_SLOTS));
  assign ser_data  = running & frame_vec[slot];
  assign ser_clk   = running && in_data && clk_high_phase(int'(cyc), int'(len));

endmodule

// File: rtl/frame_ser_tx.sv
module frame_ser_tx
  import fst_pkg::*;
#(
  parameter int DATA_W  = 22,
  parameter int PAD_W   = 2,
  parameter int SLOT_M1 = 8,
  parameter int SLOT_M2 = 4,
  parameter int SLOT_M3 = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [1:0]        range_sel,
  input  logic              strobe,
  input  logic [DATA_W-1:0] din,
  output logic              ser_data,
  output logic              ser_clk
);

  localparam int PAY_W       = DATA_W + PAD_W;
  localparam int FRAME_SLOTS = PAY_W + BOUND_SLOTS;
  localparam int SLOT_W      = $clog2(FRAME_SLOTS);
  localparam int MAX_LEN     = max3(SLOT_M1, SLOT_M2, 2 * SLOT_M3);
  localparam int CYC_W       = $clog2(MAX_LEN + 1);

  logic              go_ok;
  logic              strobe_rise;
  logic [DATA_W-1:0] held;
  logic [CYC_W-1:0]  len_sel;
  logic [CYC_W-1:0]  cyc;
  logic [CYC_W-1:0]  len_q;
  logic              slot_end;
  logic              start;
  logic              frame_done;
  logic              running;
  logic [SLOT_W-1:0] slot;

  assign go_ok   = enable && (range_e'(range_sel) != RANGE_OFF);
  assign len_sel = CYC_W'(slot_cycles(range_e'(range_sel), SLOT_M1, SLOT_M2, SLOT_M3));

  fst_capture #(.DATA_W(DATA_W)) u_cap (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .din         (din),
    .strobe_rise (strobe_rise),
    .held        (held)
  );

  fst_slot_timer #(.CYC_W(CYC_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start),
    .len_in   (len_sel),
    .run      (running),
    .cyc      (cyc),
    .len      (len_q),
    .slot_end (slot_end)
  );

  fst_framer #(
    .DATA_W      (DATA_W),
    .PAD_W       (PAD_W),
    .FRAME_SLOTS (FRAME_SLOTS),
    .SLOT_W      (SLOT_W),
    .CYC_W       (CYC_W)
  ) u_frm (
    .clk        (clk),
    .rst_n      (rst_n),
    .go_ok      (go_ok),
    .slot_end   (slot_end),
    .held       (held),
    .cyc        (cyc),
    .len        (len_q),
    .start      (start),
    .frame_done (frame_done),
    .running    (running),
    .slot       (slot),
    .ser_data   (ser_data),
    .ser_clk    (ser_clk)
  );

endmodule

// File: rtl/fst_chk.sv
module fst_chk #(
  parameter int DATA_W      = 22,
  parameter int PAD_W       = 2,
  parameter int FRAME_SLOTS = 26,
  parameter int SLOT_W      = 5,
  parameter int CYC_W       = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              go_ok,
  input logic              strobe_rise,
  input logic [DATA_W-1:0] din,
  input logic [DATA_W-1:0] held,
  input logic              start,
  input logic              frame_done,
  input logic              running,
  input logic [SLOT_W-1:0] slot,
  input logic [CYC_W-1:0]  len_q,
  input logic              ser_data,
  input logic              ser_clk
);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (!ser_data && !ser_clk));

  // R2
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot <= SLOT_W'(FRAME_SLOTS - 1));

  // R3
  mark_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && slot == SLOT_W'(0)) |-> (ser_data && !ser_clk));

  // R3
  mark_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && slot == SLOT_W'(1)) |-> (!ser_data && !ser_clk));

  // R5
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && slot >= SLOT_W'(FRAME_SLOTS - PAD_W)) |-> !ser_data);

  // R6
  data_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk && $past(ser_clk)) |-> $stable(ser_data));

  // R7
  len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(len_q));

  // R8
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_rise |=> (held == $past(din)));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_rise |=> $stable(held));

  // R9
  stop_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !enable) |=> !running);

  // R10
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && go_ok) |=> (running && slot == SLOT_W'(0)));

endmodule

bind frame_ser_tx fst_chk #(
  .DATA_W      (DATA_W),
  .PAD_W       (PAD_W),
  .FRAME_SLOTS (FRAME_SLOTS),
  .SLOT_W      (SLOT_W),
  .CYC_W       (CYC_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .enable      (enable),
  .go_ok       (go_ok),
  .strobe_rise (strobe_rise),
  .din         (din),
  .held        (held),
  .start       (start),
  .frame_done  (frame_done),
  .running     (running),
  .slot        (slot),
  .len_q       (len_q),
  .ser_data    (ser_data),
  .ser_clk     (ser_clk)
);

// File: tb/frame_ser_tx_tb.sv
`timescale 1ns/1ps
module frame_ser_tx_tb;

  localparam int DW = 22;
  localparam int M1 = 4;
  localparam int M2 = 2;
  localparam int M3 = 3;
  localparam logic [DW-1:0] W0   = 22'h2A5C31;
  localparam logic [DW-1:0] W1   = 22'h13F0E6;
  localparam logic [DW-1:0] W2   = 22'h0C0303;
  localparam logic [DW-1:0] ONES = 22'h3FFFFF;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enable = 1'b0;
  logic [1:0]    range_sel = 2'd0;
  logic          strobe = 1'b0;
  logic [DW-1:0] din = '0;
  logic          ser_data;
  logic          ser_clk;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  frame_ser_tx #(
    .DATA_W(DW), .PAD_W(2), .SLOT_M1(M1), .SLOT_M2(M2), .SLOT_M3(M3)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .range_sel(range_sel),
    .strobe(strobe), .din(din), .ser_data(ser_data), .ser_clk(ser_clk)
  );

  task automatic note(input bit ok, input string req, input string what,
                      input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Outputs must stay low for the given number of cycles.
  task automatic check_idle(input int cycles, input string req);
    int bad = 0;
    int act = 0;
    for (int i = 0; i < cycles; i++) begin
      if (ser_data !== 1'b0 || ser_clk !== 1'b0) begin
        if (bad == 0) act = {ser_data, ser_clk};
        bad++;
      end
      @(negedge clk);
    end
    note(bad == 0, req, "idle outputs {data,clk}", act, 0);
  endtask

  task automatic do_strobe(input logic [DW-1:0] w);
    din = w;
    strobe = 1'b1;
    @(negedge clk);
    strobe = 1'b0;
    din = ~w;
    @(negedge clk);
  endtask

  // Called at the negedge where slot 0, cycle 0 is visible. Samples every
  // cycle of one frame of slot length len. Optional mid-frame stimulus.
  task automatic check_frame(input int len, input logic [DW-1:0] word,
                             input string req, input int st_at,
                             input logic [DW-1:0] st_word, input int md_at,
                             input logic [1:0] md_val, input int off_at,
                             input bit end_en, input logic [1:0] end_rng);
    int n = 26 * len;
    int bad_f = 0;
    int bad_d = 0;
    int fi = 0, fa = 0, fe = 0, di = 0, da = 0, de = 0;
    logic [23:0] pay = {2'b00, word};
    for (int i = 0; i < n; i++) begin
      int s = i / len;
      int c = i % len;
      logic ed;
      logic ec;
      ed = (s == 0) ? 1'b1 : (s == 1) ? 1'b0 : pay[s-2];
      ec = (s >= 2) && (c >= len / 2);
      if (ser_clk !== ec || (s < 2 && ser_data !== ed)) begin
        if (bad_f == 0) begin
          fi = i; fa = {ser_data, ser_clk}; fe = {ed, ec};
        end
        bad_f++;
      end
      if (s >= 2 && ser_data !== ed) begin
        if (bad_d == 0) begin
          di = i; da = ser_data; de = ed;
        end
        bad_d++;
      end
      if (i == st_at) begin
        strobe = 1'b1;
        din = st_word;
      end
      if (i == st_at + 1) strobe = 1'b0;
      if (i == st_at + 2) din = ~st_word;
      if (i == md_at) range_sel = md_val;
      if (i == off_at) enable = 1'b0;
      if (i == n - 1) begin
        enable = end_en;
        range_sel = end_rng;
      end
      @(negedge clk);
    end
    // R2 R3 R6: boundary marker, clock phase and frame length
    note(bad_f == 0, req, $sformatf("R3 R6 framing {data,clk} at cycle %0d", fi), fa, fe);
    // R4 R5: payload content and order
    note(bad_d == 0, req, $sformatf("R4 R5 payload bit at cycle %0d", di), da, de);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog R10 actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    note(ser_data === 1'b0 && ser_clk === 1'b0, "R1", "outputs in reset",
         {ser_data, ser_clk}, 0);
    rst_n = 1'b1;
    check_idle(4, "R1");

    // R8: capture on rising strobe; the din change afterwards is ignored
    do_strobe(W0);

    // R10: start from idle in range 1; R7: range change mid-frame
    enable = 1'b1;
    range_sel = 2'd1;
    @(negedge clk);
    check_frame(M1, W0, "R2 R10 range1", 10, W1, 20, 2'd2, -1, 1'b1, 2'd2);
    // R7 R8: new range and new word only from the next frame
    check_frame(M2, W1, "R7 R8 range2 next word", -1, '0, -1, 2'd0, -1, 1'b1, 2'd2);
    // R8: back-to-back frame repeats the held word
    check_frame(M2, W1, "R8 repeat", -1, '0, -1, 2'd0, -1, 1'b1, 2'd3);
    // R7: half-rate range
    check_frame(2 * M3, W1, "R7 range3", 5, W2, -1, 2'd0, -1, 1'b1, 2'd3);
    check_frame(2 * M3, W2, "R8 range3 next word", -1, '0, -1, 2'd0, -1, 1'b0, 2'd3);
    // R9: enable low at frame end
    check_idle(30, "R9 stop");

    // R9: range zero keeps the block idle even when enabled
    range_sel = 2'd0;
    enable = 1'b1;
    check_idle(20, "R9 range0");

    // R5: all-ones word still pads with zeros; R9: enable drop mid-frame
    do_strobe(ONES);
    range_sel = 2'd1;
    @(negedge clk);
    check_frame(M1, ONES, "R5 R9 pad and finish", -1, '0, -1, 2'd0, 30, 1'b0, 2'd1);
    check_idle(20, "R9 after drop");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule